// File: doc/BRIEF.md
# Packet ping-pong transmit buffer

This block stages outgoing packets between a 64-bit local bus writer and a reader on the MAC side. It has two storage banks. Each bank holds one packet. The writer streams a packet as a run of words and flags the final word, which also carries how many of its bytes are valid. While that packet is arriving, all writes go to a single bank. When the final word is accepted, the bank is sealed with the packet's byte length and passed to the reader. The next packet then goes to the other bank.

Because of this, one packet can be prepared while the previous one is drained. The reader gets a word stream with a last flag, a per-word valid-byte count and the packet's total byte length. A bank stays with the reader until its final word has been taken. If both banks hold packets, the writer is stalled until a bank is freed. The reader always drains packets in the order they were filled.

Top module: `pp_tx_buffer`

## Requirements
- R1: After reset, wr_ready is 1 and rd_valid is 0.
- R2: One bank takes every word of a packet, up to and including the word with wr_last. The next packet is stored in the other bank.
- R3: Word k of a packet carries bytes 8k to 8k+7. A non-last word counts 8 bytes, whatever is on wr_bytes. On the last word, wr_bytes gives the valid-byte count 1..8, and a value of 0 or above 8 counts as 8.
- R4: rd_len shows the packet's byte length L for the whole read. Word k comes out with rd_data equal to the written word k. rd_last is 1 only on word ceil(L/8)-1. rd_bytes is 8, except on that last word, where it is L-8*(ceil(L/8)-1).
- R5: rd_valid is 0 in the cycle the last word of a packet is accepted into an empty buffer. It is 1 from the next cycle on.
- R6: Packets are read out in the order their last words were accepted.
- R7: While both banks hold packets, wr_ready is 0. In the cycle after the final word of the older packet is taken, wr_ready is 1 again.
- R8: While the reader holds one bank, the writer can still fill the other bank: wr_ready stays 1 while rd_valid is 1.
- R9: While rd_valid is 1 and rd_ready is 0, rd_valid stays 1 and rd_data and rd_len stay unchanged.
- R10: Bytes past MAX_BYTES (1500) are dropped. The recorded length is capped at MAX_BYTES, and the packet still ends at its wr_last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write word offered |
| wr_data | input | DATA_W | Write word |
| wr_last | input | 1 | Word is the last of its packet |
| wr_bytes | input | 4 | Valid bytes on the last word |
| wr_ready | output | 1 | Word accepted this cycle when valid |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Reader takes the word |
| rd_data | output | DATA_W | Read word |
| rd_last | output | 1 | Word is the last of the packet |
| rd_bytes | output | 4 | Valid bytes in this word |
| rd_len | output | 11 | Byte length of the packet being read |

## Verification
The bench builds the block with DATA_W=64 and MAX_BYTES=1500, which gives 188-word banks. With these values, a 190-word packet reaches the dropping and length-capping path. Exact-fit packets of 1500 and 1496 bytes test the last-word byte arithmetic at the bank's edge. Random packets cover every wr_bytes code from 0 to 15 and random junk on non-last words. The reader stalls at random, so at times both banks are full and at times they drain while filling.

// File: rtl/pp_buf_pkg.sv
package pp_buf_pkg;
    // Bank selector; the buffer alternates strictly between the two.
    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_sel_e;

    function automatic bank_sel_e other_bank(input bank_sel_e b);
        return (b == BANK_A) ? BANK_B : BANK_A;
    endfunction
endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
    parameter int DATA_W    = 64,
    parameter int DEPTH     = 188,
    parameter int AW        = 8,
    parameter int LEN_W     = 11,
    parameter int MAX_BYTES = 1500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              seal,
    input  logic [LEN_W-1:0]  seal_len,
    input  logic              drain_done,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              full,
    output logic [LEN_W-1:0]  len
);
    typedef struct packed {
        logic             full;
        logic [LEN_W-1:0] len;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (seal) begin
            st_d.full = 1'b1;
            st_d.len  = seal_len;
        end else if (drain_done) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
    assign full  = st_q.full;
    assign len   = st_q.len;

    // R2
    seal_into_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seal |-> !st_q.full);
    // R6
    drain_of_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done |-> st_q.full);
    // R10
    held_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full |-> (st_q.len != '0 && st_q.len <= LEN_W'(MAX_BYTES)));
endmodule

// File: rtl/pp_wr_ctrl.sv
module pp_wr_ctrl
    import pp_buf_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int MAX_BYTES = 1500,
    parameter int BPW       = 8,
    parameter int DEPTH     = 188,
    parameter int AW        = 8,
    parameter int CNT_W     = 8,
    parameter int LEN_W     = 11,
    parameter int BV_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic [BV_W-1:0]   wr_bytes,
    input  logic [1:0]        bank_full,
    output logic              wr_ready,
    output logic [1:0]        bank_we,
    output logic [AW-1:0]     bank_waddr,
    output logic [DATA_W-1:0] bank_wdata,
    output logic [1:0]        seal,
    output logic [LEN_W-1:0]  seal_len
);
    typedef struct packed {
        bank_sel_e        sel;
        logic [CNT_W-1:0] cnt;
        logic [LEN_W-1:0] len;
    } wr_st_t;

    wr_st_t st_d, st_q;

    logic              fire;
    logic              room;
    logic [BV_W-1:0]   eff;
    logic [LEN_W:0]    sum;
    logic [LEN_W-1:0]  len_n;

    always_comb begin
        st_d     = st_q;
        wr_ready = !bank_full[st_q.sel];
        fire     = wr_valid && wr_ready;
        room     = st_q.cnt < CNT_W'(DEPTH);
        if (!wr_last || wr_bytes == '0 || wr_bytes > BV_W'(BPW)) eff = BV_W'(BPW);
        else                                                    eff = wr_bytes;
        sum   = {1'b0, st_q.len} + (LEN_W+1)'(eff);
        len_n = (sum > (LEN_W+1)'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : sum[LEN_W-1:0];

        bank_we    = '0;
        seal       = '0;
        seal_len   = len_n;
        bank_waddr = st_q.cnt[AW-1:0];
        bank_wdata = wr_data;

        if (fire && room) bank_we[st_q.sel] = 1'b1;
        if (fire) begin
            if (wr_last) begin
                seal[st_q.sel] = 1'b1;
                st_d.sel = other_bank(st_q.sel);
                st_d.cnt = '0;
                st_d.len = '0;
            end else begin
                if (room) st_d.cnt = st_q.cnt + CNT_W'(1);
                st_d.len = len_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sel: BANK_A, cnt: '0, len: '0};
        else        st_q <= st_d;
    end

    // R2
    single_write_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));
    // R2
    switch_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && wr_last) |=> (st_q.sel != $past(st_q.sel)));
    // R10
    seal_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|seal) |-> (seal_len != '0 && seal_len <= LEN_W'(MAX_BYTES)));
endmodule

// File: rtl/pp_rd_ctrl.sv
module pp_rd_ctrl
    import pp_buf_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int BPW    = 8,
    parameter int SH     = 3,
    parameter int DEPTH  = 188,
    parameter int AW     = 8,
    parameter int LEN_W  = 11,
    parameter int BV_W   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_ready,
    input  logic [1:0]             bank_full,
    input  logic [1:0][LEN_W-1:0]  bank_len,
    input  logic [1:0][DATA_W-1:0] bank_rdata,
    output logic                   rd_valid,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   rd_last,
    output logic [BV_W-1:0]        rd_bytes,
    output logic [LEN_W-1:0]       rd_len,
    output logic [AW-1:0]          bank_raddr,
    output logic [1:0]             drain_done
);
    typedef struct packed {
        bank_sel_e     sel;
        logic [AW-1:0] addr;
    } rd_st_t;

    rd_st_t st_d, st_q;
    logic [LEN_W-1:0] last_idx;

    always_comb begin
        st_d       = st_q;
        drain_done = '0;
        rd_valid   = bank_full[st_q.sel];
        rd_len     = bank_len[st_q.sel];
        rd_data    = bank_rdata[st_q.sel];
        bank_raddr = st_q.addr;
        last_idx   = (rd_len - LEN_W'(1)) >> SH;
        rd_last    = (LEN_W'(st_q.addr) == last_idx);
        rd_bytes   = rd_last ? BV_W'(rd_len - (last_idx << SH)) : BV_W'(BPW);
        if (rd_valid && rd_ready) begin
            if (rd_last) begin
                drain_done[st_q.sel] = 1'b1;
                st_d.sel  = other_bank(st_q.sel);
                st_d.addr = '0;
            end else begin
                st_d.addr = st_q.addr + AW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sel: BANK_A, addr: '0};
        else        st_q <= st_d;
    end

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_len)));
    // R6
    drain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && rd_last) |=> (st_q.sel != $past(st_q.sel)));
    // R4
    byte_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_bytes != '0 && rd_bytes <= BV_W'(BPW)));
    // R4
    read_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (st_q.addr < AW'(DEPTH)));
endmodule

// File: rtl/pp_tx_buffer.sv
module pp_tx_buffer #(
    parameter int DATA_W    = 64,
    parameter int MAX_BYTES = 1500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic [3:0]        wr_bytes,
    output logic              wr_ready,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic [3:0]        rd_bytes,
    output logic [$clog2(MAX_BYTES+1)-1:0] rd_len
);
    localparam int BPW   = DATA_W / 8;
    localparam int SH    = $clog2(BPW);
    localparam int DEPTH = (MAX_BYTES + BPW - 1) / BPW;
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int LEN_W = $clog2(MAX_BYTES + 1);
    localparam int BV_W  = 4;
    localparam int NBANK = 2;

    logic [NBANK-1:0]             bank_we;
    logic [AW-1:0]                bank_waddr;
    logic [DATA_W-1:0]            bank_wdata;
    logic [NBANK-1:0]             seal;
    logic [LEN_W-1:0]             seal_len;
    logic [NBANK-1:0]             drain_done;
    logic [AW-1:0]                bank_raddr;
    logic [NBANK-1:0]             bank_full;
    logic [NBANK-1:0][LEN_W-1:0]  bank_len;
    logic [NBANK-1:0][DATA_W-1:0] bank_rdata;

    pp_wr_ctrl #(
        .DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES), .BPW(BPW), .DEPTH(DEPTH),
        .AW(AW), .CNT_W(CNT_W), .LEN_W(LEN_W), .BV_W(BV_W)
    ) u_wr (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last), .wr_bytes(wr_bytes),
        .bank_full(bank_full), .wr_ready(wr_ready),
        .bank_we(bank_we), .bank_waddr(bank_waddr), .bank_wdata(bank_wdata),
        .seal(seal), .seal_len(seal_len)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        pp_bank #(
            .DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .LEN_W(LEN_W), .MAX_BYTES(MAX_BYTES)
        ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .we(bank_we[g]), .waddr(bank_waddr), .wdata(bank_wdata),
            .seal(seal[g]), .seal_len(seal_len), .drain_done(drain_done[g]),
            .raddr(bank_raddr), .rdata(bank_rdata[g]),
            .full(bank_full[g]), .len(bank_len[g])
        );
    end

    pp_rd_ctrl #(
        .DATA_W(DATA_W), .BPW(BPW), .SH(SH), .DEPTH(DEPTH),
        .AW(AW), .LEN_W(LEN_W), .BV_W(BV_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_ready(rd_ready),
        .bank_full(bank_full), .bank_len(bank_len), .bank_rdata(bank_rdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
        .rd_bytes(rd_bytes), .rd_len(rd_len),
        .bank_raddr(bank_raddr), .drain_done(drain_done)
    );

    // R7
    both_full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&bank_full) |-> !wr_ready);
    // R5
    seal_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|seal) |=> rd_valid);
    // R2
    no_dual_seal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(seal));
endmodule

// File: tb/tb_pp_tx_buffer.sv
module tb_pp_tx_buffer;
    localparam int DW   = 64;
    localparam int MAXB = 1500;
    localparam int NRND = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_last = 1'b0;
    logic [3:0]    wr_bytes = '0;
    logic          wr_ready;
    logic          rd_valid;
    logic          rd_ready = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_last;
    logic [3:0]    rd_bytes;
    logic [10:0]   rd_len;

    int nchk = 0;
    int nerr = 0;
    int overlap = 0;
    int nw_a [NRND];
    int code_a [NRND];

    pp_tx_buffer #(.DATA_W(DW), .MAX_BYTES(MAXB)) dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last), .wr_bytes(wr_bytes),
        .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_data(rd_data), .rd_last(rd_last), .rd_bytes(rd_bytes), .rd_len(rd_len)
    );

    always #4 clk = ~clk;

    function automatic logic [63:0] data_of(input int p, input int i);
        return {8'(p) ^ 8'hA5, 8'(i), 16'(p * 131 + i * 7),
                32'(p * 32'h9E3779B1) ^ 32'(i * 32'h85EBCA6B)};
    endfunction

    // R3 / R10: expected byte length
    function automatic int exp_len(input int nw, input int code);
        int eff, l;
        eff = (code == 0 || code > 8) ? 8 : code;
        l = (nw - 1) * 8 + eff;
        return (l > MAXB) ? MAXB : l;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    // Called at a negedge; returns at the negedge after the last accept.
    task automatic write_pkt(input int pid, input int nw, input int code, input bit junk);
        logic ok;
        for (int i = 0; i < nw; i++) begin
            wr_valid = 1'b1;
            wr_data  = data_of(pid, i);
            wr_last  = (i == nw - 1);
            wr_bytes = (i == nw - 1) ? 4'(code) : (junk ? 4'($urandom) : 4'd0);
            forever begin
                ok = wr_ready;
                @(posedge clk);
                if (ok) break;
                @(negedge clk);
            end
            @(negedge clk);
        end
        wr_valid = 1'b0;
        wr_last  = 1'b0;
    endtask

    // Called at a negedge; returns at the negedge after the final handshake.
    task automatic read_pkt(input int pid, input int nw, input int code, input int pct);
        int l, nrd, i;
        l = exp_len(nw, code);
        nrd = (l + 7) / 8;
        i = 0;
        while (i < nrd) begin
            rd_ready = (($urandom % 100) < pct);
            if (rd_valid && rd_ready) begin
                chk("R4/R6", "rd_data", rd_data, data_of(pid, i));
                chk("R4", "rd_len", 64'(rd_len), 64'(l));
                chk("R4", "rd_last", 64'(rd_last), 64'(i == nrd - 1));
                chk("R4", "rd_bytes", 64'(rd_bytes),
                    64'((i == nrd - 1) ? (l - 8 * (nrd - 1)) : 8));
                i++;
            end
            @(posedge clk);
            @(negedge clk);
        end
        rd_ready = 1'b0;
    endtask

    always @(negedge clk)
        if (rst_n && wr_valid && wr_ready && rd_valid) overlap++;

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [63:0] hold_d;
        logic [10:0] hold_l;
        void'($urandom(32'd4242));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1", "wr_ready after reset", 64'(wr_ready), 64'd1);
        chk("R1", "rd_valid after reset", 64'(rd_valid), 64'd0);

        // R5: one-word packet, 3 bytes
        wr_valid = 1'b1; wr_data = data_of(0, 0); wr_last = 1'b1; wr_bytes = 4'd3;
        chk("R5", "rd_valid in accept cycle", 64'(rd_valid), 64'd0);
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0; wr_last = 1'b0;
        chk("R5", "rd_valid after accept", 64'(rd_valid), 64'd1);
        chk("R5", "rd_len after accept", 64'(rd_len), 64'd3);
        // R8: other bank still writable while reader owns one
        chk("R8", "wr_ready while reader holds bank", 64'(wr_ready), 64'd1);

        // R3: last-word code 0 counts as 8
        write_pkt(1, 3, 0, 1'b1);
        // R7
        chk("R7", "wr_ready with both banks full", 64'(wr_ready), 64'd0);

        // R9: stalled reader sees steady output
        hold_d = rd_data;
        hold_l = rd_len;
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
            chk("R9", "rd_valid held", 64'(rd_valid), 64'd1);
            chk("R9", "rd_data held", rd_data, hold_d);
            chk("R9", "rd_len held", 64'(rd_len), 64'(hold_l));
        end

        // R7: writer stalls until oldest packet drained; code 12 counts as 8
        fork
            write_pkt(2, 2, 12, 1'b1);
            begin
                repeat (4) begin
                    chk("R7", "wr_ready stalled", 64'(wr_ready), 64'd0);
                    @(posedge clk);
                    @(negedge clk);
                end
                read_pkt(0, 1, 3, 100);
                chk("R7", "wr_ready after drain", 64'(wr_ready), 64'd1);
            end
        join
        // R6: order kept
        read_pkt(1, 3, 0, 60);
        read_pkt(2, 2, 12, 50);

        // R10: oversize packet, 190 full words
        fork
            write_pkt(3, 190, 8, 1'b1);
            read_pkt(3, 190, 8, 80);
        join
        // R4 bank edge: exactly 1500 and 1496 bytes
        fork
            begin
                write_pkt(4, 188, 4, 1'b0);
                write_pkt(5, 187, 8, 1'b0);
            end
            begin
                read_pkt(4, 188, 4, 90);
                read_pkt(5, 187, 8, 70);
            end
        join

        // Random traffic, R2/R3/R4/R6/R8
        for (int k = 0; k < NRND; k++) begin
            nw_a[k]   = ((k % 8) == 7) ? 1 + int'($urandom % 190) : 1 + int'($urandom % 40);
            code_a[k] = int'($urandom % 16);
        end
        fork
            for (int k = 0; k < NRND; k++) begin
                repeat (int'($urandom % 4)) @(negedge clk);
                write_pkt(10 + k, nw_a[k], code_a[k], 1'b1);
            end
            for (int k = 0; k < NRND; k++)
                read_pkt(10 + k, nw_a[k], code_a[k], 30 + int'($urandom % 70));
        join
        // R8: fills overlapped with pending reads
        chk("R8", "overlapped fill cycles seen", 64'(overlap > 0), 64'd1);
        chk("R6", "rd_valid after all drained", 64'(rd_valid), 64'd0);
        summary();
    end
endmodule